// File: doc/BRIEF.md
# ADC Event Interrupt Controller

This block gathers five event lines from an ADC peripheral and folds them into a single interrupt request. The events are end of conversion, FIFO not empty, conversion-sequence timeout, high-threshold crossing and low-threshold crossing. Software sets the block up through a byte-wide register port. Each event bit has its own trigger type: edge or level. It also has two independent sensitivity enables. For a level source the enables mean "active high" and "active low". For an edge source they mean "rising" and "falling". Each bit also has an interrupt enable, which is set and cleared through separate write-one registers.

The event lines are sampled once per clock. A qualifying event sets a sticky pending bit. The interrupt output is high while any pending bit is also enabled. A write of one to the clear register drops both the enable and the pending latch of that bit. A level source that is still active therefore re-latches on the next cycle.

The register port is plain control: a write strobe with address and data, and a read data bus that follows the address combinationally. There is no stream traffic, so no valid/ready handshake applies.

Top module: `adc_irq_ctrl`

## Requirements
- R1: After reset, every readable register returns 0x00 and `irq_out` is low.
- R2: Reads return the register selected by `reg_addr` with bits 7:5 always 0. The mapped offsets are:
  - 0x10: live event level, one cycle after sampling.
  - 0x11: trigger type.
  - 0x12: high/rising enable.
  - 0x13: low/falling enable.
  - 0x15 and 0x16: the interrupt enable.
  - Any other offset reads 0x00.
- R3: Writing ones to 0x15 sets the matching enable bits. Writing ones to 0x16 clears them. Zero bits leave the enables unchanged.
- R4: For an edge source (type bit 1) with the high enable set, a 0-to-1 input change sets pending. `irq_out` rises by the second clock edge after the input changes.
- R5: For an edge source with the low enable set, a 1-to-0 input change sets pending.
- R6: For a level source (type bit 0), pending is set on every cycle the sampled level matches an enabled sensitivity (high enable with level 1, low enable with level 0). An inactive level sets nothing.
- R7: A pending bit stays set after its event goes away, until a clear write.
- R8: A write of one to 0x16 clears that bit's pending latch. An event detected in the same cycle as the clear wins and leaves pending set.
- R9: `irq_out` is the OR over all bits of (pending AND enable). A pending bit whose enable is off causes no interrupt until its enable is set.
- R10: Writes to unmapped offsets and to the read-only 0x10 change no register.
- R11: An edge source with both enables set latches on both rising and falling changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| evt_in | input | 5 | Event lines, bit0 end of conversion through bit4 low threshold |
| irq_out | output | 1 | Interrupt request |

## Verification
The embedded assertions check three things on every cycle:
- Pending bits only rise after a detected event.
- Pending bits hold unless cleared.
- A clear with no simultaneous event empties the latch. Enable set and clear writes land on the right bits, and ignored writes leave the configuration stable.

Only the bench scenarios can show the following:
- Edge polarity selection and level re-latching after a clear.
- The same-cycle clear-versus-event race.
- The two-edge latency from input to interrupt.
- The exact read map, including zeroed upper bits.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

  localparam int unsigned OFS_LEVEL = 32'h10;
  localparam int unsigned OFS_TYPE  = 32'h11;
  localparam int unsigned OFS_HIPOL = 32'h12;
  localparam int unsigned OFS_LOPOL = 32'h13;
  localparam int unsigned OFS_ENSET = 32'h15;
  localparam int unsigned OFS_ENCLR = 32'h16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_TYPE,
    SEL_HIPOL,
    SEL_LOPOL,
    SEL_ENSET,
    SEL_ENCLR
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [31:0] a);
    reg_sel_e s;
    case (a)
      OFS_LEVEL: s = SEL_LEVEL;
      OFS_TYPE:  s = SEL_TYPE;
      OFS_HIPOL: s = SEL_HIPOL;
      OFS_LOPOL: s = SEL_LOPOL;
      OFS_ENSET: s = SEL_ENSET;
      OFS_ENCLR: s = SEL_ENCLR;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/adc_irq_regs.sv
module adc_irq_regs
  import adc_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NSRC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   level_q,
  output logic [NSRC-1:0]   type_q,
  output logic [NSRC-1:0]   hipol_q,
  output logic [NSRC-1:0]   lopol_q,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   clr_pulse,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned PAD_W = DATA_W - NSRC;

  reg_sel_e        sel;
  logic [NSRC-1:0] wbits;

  assign sel   = decode_addr(32'(addr));
  assign wbits = wdata[NSRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q  <= '0;
      hipol_q <= '0;
      lopol_q <= '0;
      en_q    <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_TYPE:  type_q  <= wbits;
        SEL_HIPOL: hipol_q <= wbits;
        SEL_LOPOL: lopol_q <= wbits;
        SEL_ENSET: en_q    <= en_q | wbits;
        SEL_ENCLR: en_q    <= en_q & ~wbits;
        default:   ;
      endcase
    end
  end

  assign clr_pulse = (wr_en && sel == SEL_ENCLR) ? wbits : '0;

  always_comb begin
    logic [NSRC-1:0] v;
    case (sel)
      SEL_LEVEL: v = level_q;
      SEL_TYPE:  v = type_q;
      SEL_HIPOL: v = hipol_q;
      SEL_LOPOL: v = lopol_q;
      SEL_ENSET: v = en_q;
      SEL_ENCLR: v = en_q;
      default:   v = '0;
    endcase
    rdata = {{PAD_W{1'b0}}, v};
  end

  // R3: set writes raise the written enable bits
  assert_enset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_ENSET) |=> ((en_q & $past(wbits)) == $past(wbits)));

  // R3: clear writes drop the written enable bits
  assert_enclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_ENCLR) |=> ((en_q & $past(wbits)) == '0));

  // R10: unmapped or read-only offsets leave configuration untouched
  assert_ignored_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_NONE || sel == SEL_LEVEL)) |=>
      ($stable(type_q) && $stable(hipol_q) && $stable(lopol_q) && $stable(en_q)));

endmodule

// File: rtl/adc_irq_detect.sv
module adc_irq_detect #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_in,
  input  logic [NSRC-1:0] type_q,
  input  logic [NSRC-1:0] hipol_q,
  input  logic [NSRC-1:0] lopol_q,
  output logic [NSRC-1:0] level_q,
  output logic [NSRC-1:0] hit
);

  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      prev_q  <= '0;
    end else begin
      level_q <= evt_in;
      prev_q  <= level_q;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = level_q[g] & ~prev_q[g];
    assign fall     = ~level_q[g] & prev_q[g];
    assign edge_hit = (hipol_q[g] & rise) | (lopol_q[g] & fall);
    assign lvl_hit  = (hipol_q[g] & level_q[g]) | (lopol_q[g] & ~level_q[g]);
    assign hit[g]   = type_q[g] ? edge_hit : lvl_hit;
  end

endmodule

// File: rtl/adc_irq_pending.sv
module adc_irq_pending #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hit,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] pend_q,
  output logic            irq
);

  for (genvar g = 0; g < NSRC; g++) begin : g_latch
    logic p;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p <= 1'b0;
      else        p <= (p & ~clr[g]) | hit[g];
    end
    assign pend_q[g] = p;
  end

  assign irq = |(pend_q & en);

  // R4: a pending bit only rises after a detected event
  assert_pend_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0));

  // R7: a pending bit holds unless cleared
  assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr)) == $past(pend_q & ~clr)));

  // R8: a clear with no simultaneous event empties the latch
  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr & ~hit)) == '0));

endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NSRC   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   evt_in,
  output logic              irq_out
);

  logic [NSRC-1:0] level_q, type_q, hipol_q, lopol_q, en_q, clr_pulse;
  logic [NSRC-1:0] hit, pend_q;

  adc_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .level_q   (level_q),
    .type_q    (type_q),
    .hipol_q   (hipol_q),
    .lopol_q   (lopol_q),
    .en_q      (en_q),
    .clr_pulse (clr_pulse),
    .rdata     (reg_rdata)
  );

  adc_irq_detect #(.NSRC(NSRC)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_in  (evt_in),
    .type_q  (type_q),
    .hipol_q (hipol_q),
    .lopol_q (lopol_q),
    .level_q (level_q),
    .hit     (hit)
  );

  adc_irq_pending #(.NSRC(NSRC)) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .clr    (clr_pulse),
    .en     (en_q),
    .pend_q (pend_q),
    .irq    (irq_out)
  );

endmodule

// File: tb/adc_irq_ctrl_test.sv
module adc_irq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NVEC       = 37;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [4:0] evt = 5'h00;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_irq_ctrl uut (
    .clk (clk), .rst_n (rst_n), .reg_wr_en (wr), .reg_addr (addr),
    .reg_wdata (wdata), .reg_rdata (rdata), .evt_in (evt), .irq_out (irq)
  );

  // {wr, addr, wdata, evt, exp_irq, chk_addr, exp_rdata}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1,8'h11,8'h03,5'h00,1'b0,8'h11,8'h03}, // 0  R2 type
    {1'b1,8'h12,8'h05,5'h00,1'b0,8'h12,8'h05}, // 1  R2 high
    {1'b1,8'h13,8'h0A,5'h00,1'b0,8'h13,8'h0A}, // 2  R9 bit3 latches, not enabled
    {1'b1,8'h15,8'h01,5'h00,1'b0,8'h15,8'h01}, // 3  R3 set
    {1'b0,8'h00,8'h00,5'h01,1'b1,8'h10,8'h01}, // 4  R4 rise
    {1'b0,8'h00,8'h00,5'h00,1'b1,8'h10,8'h00}, // 5  R7 sticky
    {1'b1,8'h16,8'h01,5'h00,1'b0,8'h15,8'h00}, // 6  R8 clear
    {1'b1,8'h15,8'h01,5'h00,1'b0,8'h15,8'h01}, // 7  R8 pending gone
    {1'b1,8'h15,8'h08,5'h00,1'b1,8'h16,8'h09}, // 8  R9 late enable
    {1'b1,8'h16,8'h08,5'h00,1'b0,8'h15,8'h01}, // 9  R6 clear, level active
    {1'b1,8'h15,8'h08,5'h08,1'b1,8'h10,8'h08}, // 10 R6 relatched
    {1'b1,8'h16,8'h08,5'h08,1'b0,8'h15,8'h01}, // 11 R8
    {1'b1,8'h15,8'h08,5'h08,1'b0,8'h15,8'h09}, // 12 R6 inactive level
    {1'b1,8'h16,8'h08,5'h08,1'b0,8'h15,8'h01}, // 13 R3
    {1'b1,8'h15,8'h02,5'h0A,1'b0,8'h10,8'h0A}, // 14 R5 rise ignored
    {1'b0,8'h00,8'h00,5'h08,1'b1,8'h10,8'h08}, // 15 R5 fall
    {1'b1,8'h16,8'h02,5'h08,1'b0,8'h15,8'h01}, // 16 R8
    {1'b1,8'h40,8'hFF,5'h08,1'b0,8'h15,8'h01}, // 17 R10
    {1'b1,8'h40,8'hFF,5'h08,1'b0,8'h11,8'h03}, // 18 R10
    {1'b1,8'h10,8'hFF,5'h08,1'b0,8'h10,8'h08}, // 19 R10 read-only
    {1'b1,8'h14,8'hFF,5'h08,1'b0,8'h14,8'h00}, // 20 R2 hole reads zero
    {1'b1,8'h17,8'hFF,5'h08,1'b0,8'h15,8'h01}, // 21 R10
    {1'b1,8'h15,8'h04,5'h0C,1'b1,8'h15,8'h05}, // 22 R6 high level
    {1'b1,8'h16,8'h04,5'h0C,1'b0,8'h15,8'h01}, // 23 R6
    {1'b1,8'h15,8'h04,5'h08,1'b1,8'h10,8'h08}, // 24 R6 relatched
    {1'b1,8'h16,8'h04,5'h08,1'b0,8'h15,8'h01}, // 25 R8
    {1'b1,8'h15,8'h04,5'h08,1'b0,8'h15,8'h05}, // 26 R6 no relatch
    {1'b1,8'h16,8'h04,5'h08,1'b0,8'h15,8'h01}, // 27 R3
    {1'b1,8'h11,8'hFF,5'h08,1'b0,8'h11,8'h1F}, // 28 R2 upper bits zero
    {1'b1,8'h12,8'h15,5'h08,1'b0,8'h12,8'h15}, // 29 R2
    {1'b1,8'h13,8'h1A,5'h08,1'b0,8'h13,8'h1A}, // 30 R2
    {1'b1,8'h15,8'h10,5'h08,1'b0,8'h15,8'h11}, // 31 R3
    {1'b0,8'h00,8'h00,5'h18,1'b1,8'h10,8'h18}, // 32 R11 rise
    {1'b1,8'h16,8'h10,5'h18,1'b0,8'h15,8'h01}, // 33 R8
    {1'b1,8'h15,8'h10,5'h18,1'b0,8'h15,8'h11}, // 34 R9
    {1'b0,8'h00,8'h00,5'h08,1'b1,8'h10,8'h08}, // 35 R11 fall
    {1'b1,8'h16,8'h10,5'h08,1'b0,8'h15,8'h01}  // 36 R8
  };

  string VTAG [NVEC] = '{
    "R2","R2","R9","R3","R4","R7","R8","R8","R9","R6",
    "R6","R8","R6","R3","R5","R5","R8","R10","R10","R10",
    "R2","R10","R6","R6","R6","R8","R6","R3","R2","R2",
    "R2","R3","R11","R8","R9","R11","R8"
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic [4:0] s, input logic ei, input logic [7:0] ca,
                      input logic [7:0] er, input string tag);
    @(negedge clk);
    wr = w; addr = a; wdata = d; evt = s;
    @(negedge clk);
    wr = 1'b0; addr = ca;
    @(negedge clk);
    check(irq == ei, {tag, " irq"}, int'(irq), int'(ei));
    check(rdata == er, {tag, " rdata"}, int'(rdata), int'(er));
  endtask

  task automatic check_all_zero(input string tag);
    for (int a = 8'h10; a <= 8'h16; a++) begin
      addr = 8'(a);
      #1;
      check(rdata == 8'h00, tag, int'(rdata), 0);
    end
    check(irq == 1'b0, tag, int'(irq), 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all_zero("R1 reset state");

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][38], VEC[i][37:30], VEC[i][29:22], VEC[i][21:17],
           VEC[i][16], VEC[i][15:8], VEC[i][7:0], VTAG[i]);
    end

    // R8: bit4 rising edge detected in the same cycle as its clear write
    @(negedge clk);
    evt = 5'h18;
    @(negedge clk);
    wr = 1'b1; addr = 8'h16; wdata = 8'h10;
    @(negedge clk);
    wr = 1'b0; addr = 8'h15;
    #1;
    check(irq == 1'b0, "R8 clear disables", int'(irq), 0);
    check(rdata == 8'h01, "R8 enable cleared", int'(rdata), 1);
    step(1'b1, 8'h15, 8'h10, 5'h18, 1'b1, 8'h15, 8'h11, "R8 event beats clear");
    step(1'b1, 8'h16, 8'h10, 5'h18, 1'b0, 8'h15, 8'h01, "R8 cleanup");

    // R1: reset in the middle of activity
    @(negedge clk);
    evt = 5'h00;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all_zero("R1 mid-run reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule